// File: doc/BRIEF.md
# Bit-Serial Keyboard and Mouse Message Receiver

This block collects a keyboard-and-mouse message that arrives one bit at a time. Each bit comes with a one-cycle valid strobe; in a display system that strobe fires once per scanline. A one received while the receiver is idle opens a message. The fields that follow, each sent MSB first, are a signed X mouse delta, a signed Y mouse delta, a button field and a status field. An 8-bit key code follows only when the status field asks for it. Each field length is held in a counter loaded with the negative of that length. The carry out of the counter's final increment moves the receiver to the next field.

The mouse deltas are sign-extended and added into two wrapping accumulators. Once per video field, a field-end strobe captures both accumulators into one packed output word, pulses a post flag and clears the accumulators. The buttons and status are held from the last completed message. Key codes go into a small first-in first-out queue that downstream logic drains with a pop strobe. A key that arrives while the queue is full is dropped and sets a sticky overrun flag.

Top module: `kbm_serial_rx`

## Requirements
- R1: After a synchronous active-low reset, mouse_word, mouse_post, buttons, status, key_valid, key_code and key_overrun are all zero, and the receiver is idle.
- R2: While idle, a valid zero bit is ignored and a valid one bit starts a message; the start bit carries no field data.
- R3: After the start bit, the fields follow in this fixed order: X delta (4 bits), Y delta (4 bits), buttons (3 bits), status (4 bits), each MSB first. Only cycles with ser_valid high advance a field.
- R4: Each completed X or Y delta is a 4-bit two's complement value. It is sign-extended to 7 bits and added, modulo 128, into its own accumulator.
- R5: mouse_word packs the X accumulator in bits 15:9 and the Y accumulator in bits 6:0; bits 8:7 are zero.
- R6: A field_end high at a clock edge makes mouse_post high for exactly the following cycle. mouse_word then holds the accumulators as they were before that edge, and both accumulators restart from zero. A delta that completes at the same edge counts toward the new field.
- R7: buttons and status update at the edge that samples their final bit. Status bit 0 is the key-follows flag; when it is zero the message ends and the receiver returns to idle.
- R8: When the key-follows flag is one, an 8-bit key code follows (bits 7:1 key number, bit 0 one for released and zero for pressed). One cycle after its last bit, the code is pushed into the key queue and the receiver returns to idle.
- R9: The key queue holds two codes in arrival order. key_valid shows that it is not empty, key_code shows the oldest code, and key_pop with key_valid high removes that code.
- R10: A key pushed while the queue holds two codes and no pop happens in the same cycle is dropped. key_overrun then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_bit | input | 1 | Serial message bit |
| ser_valid | input | 1 | One-cycle strobe qualifying ser_bit |
| field_end | input | 1 | Video field boundary strobe |
| key_pop | input | 1 | Remove the oldest queued key code |
| mouse_word | output | 16 | Packed X/Y accumulators captured at field end |
| mouse_post | output | 1 | mouse_word was captured at the previous edge |
| buttons | output | 3 | Button field of the last message |
| status | output | 4 | Status field of the last message |
| key_valid | output | 1 | Key queue is not empty |
| key_code | output | 8 | Oldest queued key code |
| key_overrun | output | 1 | Sticky key-dropped flag |

## Verification
The bench builds the block with its default parameters: 4-bit deltas, 7-bit accumulators, an 8-bit key and a two-entry key queue. With a two-entry queue, an overrun is reached after only three keyed messages. With 4-bit deltas, the extreme values +7 and -8 can be summed across several messages in one field. A delta is also made to complete in the same cycle as the field-end strobe, which checks that the snapshot and the clear happen in the right order.

// File: rtl/kbm_pkg.sv
// Shared types for the serial keyboard/mouse receiver.
package kbm_pkg;
    // Receiver sequencing states; each non-idle, non-post state is one field.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DX   = 3'd1,
        ST_DY   = 3'd2,
        ST_BTN  = 3'd3,
        ST_STS  = 3'd4,
        ST_KEY  = 3'd5,
        ST_POST = 3'd6
    } kbm_state_e;
endpackage

// File: rtl/kbm_field_seq.sv
// Field sequencer: walks a serial message field by field.
// Each field length is held as a negative count that is incremented once per
// valid bit; the carry out of the final increment ends the field.
// Assumes: bits arrive MSB first, at most one per cycle, qualified by ser_valid.
// Status bit 0 (the last status bit received) is the key-follows flag.
module kbm_field_seq
    import kbm_pkg::*;
#(
    parameter int DX_BITS  = 4,
    parameter int BTN_BITS = 3,
    parameter int STS_BITS = 4,
    parameter int KEY_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_bit,
    input  logic                ser_valid,
    output logic                dx_stb,
    output logic                dy_stb,
    output logic                btn_stb,
    output logic                sts_stb,
    output logic                key_push,
    output logic [DX_BITS-1:0]  dlt_val,
    output logic [BTN_BITS-1:0] btn_val,
    output logic [STS_BITS-1:0] sts_val,
    output logic [KEY_BITS-1:0] key_byte
);
    localparam int W1    = (DX_BITS > BTN_BITS) ? DX_BITS : BTN_BITS;
    localparam int W2    = (W1 > STS_BITS) ? W1 : STS_BITS;
    localparam int SH_W  = (W2 > KEY_BITS) ? W2 : KEY_BITS;
    localparam int CNT_W = $clog2(SH_W) + 1;

    kbm_state_e        state, state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [SH_W-1:0]   sh, sh_n, sh_next;
    logic [CNT_W:0]    cnt_inc;
    logic              last_bit;

    // Two's complement of a field length, loaded at field entry.
    function automatic logic [CNT_W-1:0] neg_len(input int unsigned n);
        neg_len = CNT_W'(0) - CNT_W'(n);
    endfunction

    assign cnt_inc  = {1'b0, cnt} + 1'b1;
    assign last_bit = cnt_inc[CNT_W];
    assign sh_next  = {sh[SH_W-2:0], ser_bit};
    assign dlt_val  = sh_next[DX_BITS-1:0];
    assign btn_val  = sh_next[BTN_BITS-1:0];
    assign sts_val  = sh_next[STS_BITS-1:0];
    assign key_byte = sh[KEY_BITS-1:0];
    assign key_push = (state == ST_POST);

    // Next-state, counter and shift decisions for the current bit.
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        sh_n    = sh;
        dx_stb  = 1'b0;
        dy_stb  = 1'b0;
        btn_stb = 1'b0;
        sts_stb = 1'b0;
        case (state)
            ST_IDLE: begin
                if (ser_valid && ser_bit) begin
                    state_n = ST_DX;
                    cnt_n   = neg_len(DX_BITS);
                end
            end
            ST_POST: state_n = ST_IDLE;
            default: begin
                if (ser_valid) begin
                    sh_n  = sh_next;
                    cnt_n = cnt_inc[CNT_W-1:0];
                    if (last_bit) begin
                        case (state)
                            ST_DX: begin
                                dx_stb  = 1'b1;
                                state_n = ST_DY;
                                cnt_n   = neg_len(DX_BITS);
                            end
                            ST_DY: begin
                                dy_stb  = 1'b1;
                                state_n = ST_BTN;
                                cnt_n   = neg_len(BTN_BITS);
                            end
                            ST_BTN: begin
                                btn_stb = 1'b1;
                                state_n = ST_STS;
                                cnt_n   = neg_len(STS_BITS);
                            end
                            ST_STS: begin
                                sts_stb = 1'b1;
                                if (sh_next[0]) begin
                                    state_n = ST_KEY;
                                    cnt_n   = neg_len(KEY_BITS);
                                end else begin
                                    state_n = ST_IDLE;
                                end
                            end
                            ST_KEY:  state_n = ST_POST;
                            default: state_n = ST_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    // State, counter and shift register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sh    <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            sh    <= sh_n;
        end
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ser_valid && ser_bit) |=> (state == ST_DX));
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(ser_valid && ser_bit)) |=> (state == ST_IDLE));
    assert_one_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dx_stb, dy_stb, btn_stb, sts_stb, key_push}));
    assert_post_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST) |=> (state == ST_IDLE));
endmodule

// File: rtl/kbm_mouse_acc.sv
// Mouse delta accumulator: sign-extends each delta and adds it, wrapping,
// into per-axis accumulators. At field end it captures both into a packed
// word (X high, two zero bits, Y low) and restarts from zero.
// Assumes: dx_stb and dy_stb are never high together.
module kbm_mouse_acc #(
    parameter int DX_BITS  = 4,
    parameter int ACC_BITS = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dx_stb,
    input  logic                    dy_stb,
    input  logic [DX_BITS-1:0]      delta,
    input  logic                    field_end,
    output logic [2*ACC_BITS+1:0]   mouse_word,
    output logic                    mouse_post
);
    localparam int EXT_W = ACC_BITS - DX_BITS;

    logic [ACC_BITS-1:0] acc_x, acc_y, sext;

    assign sext = {{EXT_W{delta[DX_BITS-1]}}, delta};

    // Accumulate deltas; a field end restarts both sums before this delta.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_x <= '0;
            acc_y <= '0;
        end else begin
            acc_x <= (field_end ? '0 : acc_x) + (dx_stb ? sext : '0);
            acc_y <= (field_end ? '0 : acc_y) + (dy_stb ? sext : '0);
        end
    end

    // Capture the packed word and pulse the post flag at field end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mouse_word <= '0;
            mouse_post <= 1'b0;
        end else begin
            mouse_post <= field_end;
            if (field_end) mouse_word <= {acc_x, 2'b00, acc_y};
        end
    end

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (field_end && !dx_stb && !dy_stb) |=> (acc_x == '0 && acc_y == '0));
    assert_hold_x_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_end && !dx_stb) |=> $stable(acc_x));
    assert_post_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!field_end) |=> !mouse_post);
endmodule

// File: rtl/kbm_key_fifo.sv
// Key code queue: a small shift-down FIFO held as one packed vector; entry 0
// is the oldest. A push while full without a pop is dropped and recorded in a
// sticky overrun flag.
// Assumes: pop is ignored while empty.
module kbm_key_fifo #(
    parameter int KEY_BITS = 8,
    parameter int DEPTH    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [KEY_BITS-1:0] push_data,
    input  logic                pop,
    output logic                valid,
    output logic [KEY_BITS-1:0] head,
    output logic                overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH*KEY_BITS-1:0] ent, ent_n;
    logic [CW-1:0]             cnt, cnt_n, wr_idx;
    logic                      do_pop, accept;

    assign do_pop = pop && (cnt != '0);
    assign accept = push && ((cnt != CW'(DEPTH)) || do_pop);
    assign wr_idx = cnt - CW'(do_pop);
    assign valid  = (cnt != '0);
    assign head   = ent[KEY_BITS-1:0];

    // Shift out the head on pop, then place an accepted code at the tail.
    always_comb begin
        ent_n = do_pop ? (ent >> KEY_BITS) : ent;
        if (accept) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wr_idx == CW'(i)) ent_n[i*KEY_BITS +: KEY_BITS] = push_data;
            end
        end
        cnt_n = cnt + CW'(accept) - CW'(do_pop);
    end

    // Queue storage, fill count and sticky overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent     <= '0;
            cnt     <= '0;
            overrun <= 1'b0;
        end else begin
            ent     <= ent_n;
            cnt     <= cnt_n;
            overrun <= overrun | (push && !accept);
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    assert_idle_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(cnt));
endmodule

// File: rtl/kbm_serial_rx.sv
// Serial keyboard/mouse receiver top: ties the field sequencer, the mouse
// accumulator and the key queue together and holds the last button and
// status fields.
// Assumes: field_end is a one-cycle strobe; key_pop is qualified by key_valid.
module kbm_serial_rx #(
    parameter int DX_BITS   = 4,
    parameter int ACC_BITS  = 7,
    parameter int BTN_BITS  = 3,
    parameter int STS_BITS  = 4,
    parameter int KEY_BITS  = 8,
    parameter int KEY_DEPTH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_bit,
    input  logic                    ser_valid,
    input  logic                    field_end,
    input  logic                    key_pop,
    output logic [2*ACC_BITS+1:0]   mouse_word,
    output logic                    mouse_post,
    output logic [BTN_BITS-1:0]     buttons,
    output logic [STS_BITS-1:0]     status,
    output logic                    key_valid,
    output logic [KEY_BITS-1:0]     key_code,
    output logic                    key_overrun
);
    logic                dx_stb, dy_stb, btn_stb, sts_stb, key_push;
    logic [DX_BITS-1:0]  dlt_val;
    logic [BTN_BITS-1:0] btn_val;
    logic [STS_BITS-1:0] sts_val;
    logic [KEY_BITS-1:0] key_byte;

    kbm_field_seq #(
        .DX_BITS (DX_BITS),
        .BTN_BITS(BTN_BITS),
        .STS_BITS(STS_BITS),
        .KEY_BITS(KEY_BITS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_bit  (ser_bit),
        .ser_valid(ser_valid),
        .dx_stb   (dx_stb),
        .dy_stb   (dy_stb),
        .btn_stb  (btn_stb),
        .sts_stb  (sts_stb),
        .key_push (key_push),
        .dlt_val  (dlt_val),
        .btn_val  (btn_val),
        .sts_val  (sts_val),
        .key_byte (key_byte)
    );

    kbm_mouse_acc #(
        .DX_BITS (DX_BITS),
        .ACC_BITS(ACC_BITS)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .dx_stb    (dx_stb),
        .dy_stb    (dy_stb),
        .delta     (dlt_val),
        .field_end (field_end),
        .mouse_word(mouse_word),
        .mouse_post(mouse_post)
    );

    kbm_key_fifo #(
        .KEY_BITS(KEY_BITS),
        .DEPTH   (KEY_DEPTH)
    ) u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (key_push),
        .push_data(key_byte),
        .pop      (key_pop),
        .valid    (key_valid),
        .head     (key_code),
        .overrun  (key_overrun)
    );

    // Hold the last completed button and status fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buttons <= '0;
            status  <= '0;
        end else begin
            if (btn_stb) buttons <= btn_val;
            if (sts_stb) status  <= sts_val;
        end
    end

    assert_btn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_stb |=> $stable(buttons));
endmodule

// File: tb/sim_kbm_serial_rx.sv
module sim_kbm_serial_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_bit = 1'b0, ser_valid = 1'b0, field_end = 1'b0, key_pop = 1'b0;
    logic [15:0] mouse_word;
    logic        mouse_post;
    logic [2:0]  buttons;
    logic [3:0]  status;
    logic        key_valid;
    logic [7:0]  key_code;
    logic        key_overrun;

    int checks = 0, failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    kbm_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_valid(ser_valid),
        .field_end(field_end), .key_pop(key_pop), .mouse_word(mouse_word),
        .mouse_post(mouse_post), .buttons(buttons), .status(status),
        .key_valid(key_valid), .key_code(key_code), .key_overrun(key_overrun)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_state = 0, m_cnt = 0, m_val = 0, m_key = 0;
    int ax = 0, ay = 0, m_btn = 0, m_sts = 0, m_word = 0;
    bit m_post = 0, m_ovf = 0;
    int q[$];

    function automatic int flen(input int s);
        case (s)
            1, 2: return 4;
            3: return 3;
            4: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic int sx4(input int v);
        return (v >= 8) ? v - 16 : v;
    endfunction

    function automatic int pack(input int x, input int y);
        return ((x & 127) << 9) | (y & 127);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_val = 0; ax = 0; ay = 0; m_btn = 0;
            m_sts = 0; m_word = 0; m_post = 0; m_ovf = 0; q.delete();
        end else begin
            if (field_end) begin
                m_word = pack(ax, ay); m_post = 1; ax = 0; ay = 0;
            end else m_post = 0;
            if (key_pop && q.size() > 0) void'(q.pop_front());
            if (m_state == 6) begin
                if (q.size() < 2) q.push_back(m_key); else m_ovf = 1;
                m_state = 0;
            end else if (ser_valid) begin
                if (m_state == 0) begin
                    if (ser_bit) begin m_state = 1; m_cnt = 0; m_val = 0; end
                end else begin
                    m_val = (m_val << 1) | int'(ser_bit);
                    m_cnt++;
                    if (m_cnt == flen(m_state)) begin
                        case (m_state)
                            1: begin ax = (ax + sx4(m_val)) & 127; m_state = 2; end
                            2: begin ay = (ay + sx4(m_val)) & 127; m_state = 3; end
                            3: begin m_btn = m_val; m_state = 4; end
                            4: begin m_sts = m_val; m_state = (m_val & 1) ? 5 : 0; end
                            default: begin m_key = m_val; m_state = 6; end
                        endcase
                        m_cnt = 0; m_val = 0;
                    end
                end
            end
        end
    end

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R5 mouse_word", mouse_word, m_word);
            check("R6 mouse_post", mouse_post, m_post);
            check("R7 buttons", buttons, m_btn);
            check("R7 status", status, m_sts);
            check("R9 key_valid", key_valid, q.size() > 0);
            if (q.size() > 0) check("R9 key_code", key_code, q[0]);
            check("R10 key_overrun", key_overrun, m_ovf);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_bit(input logic b);
        @(negedge clk); ser_bit = b; ser_valid = 1'b1;
        @(negedge clk); ser_bit = 1'b0; ser_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_field(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_msg(input int x, input int y, input int b, input int s, input int k);
        send_bit(1'b1);
        send_field(x, 4); send_field(y, 4); send_field(b, 3); send_field(s, 4);
        if (s & 1) send_field(k, 8);
        repeat (2) @(negedge clk);
    endtask

    task automatic fe_pulse(input string tag, input int exp_word);
        @(negedge clk); field_end = 1'b1;
        @(negedge clk); field_end = 1'b0;
        check({tag, " post"}, mouse_post, 1);
        check({tag, " word"}, mouse_word, exp_word);
        @(negedge clk);
        check({tag, " post drop"}, mouse_post, 0);
    endtask

    task automatic pop_key;
        @(negedge clk); key_pop = 1'b1;
        @(negedge clk); key_pop = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values.
        check("R1 mouse_word", mouse_word, 0);
        check("R1 mouse_post", mouse_post, 0);
        check("R1 buttons", buttons, 0);
        check("R1 status", status, 0);
        check("R1 key_valid", key_valid, 0);
        check("R1 key_overrun", key_overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: zeros while idle are ignored, then a message decodes normally.
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        send_msg(3, 4'hE, 5, 4'hA, 0);
        check("R3 buttons field", buttons, 5);
        check("R7 status field", status, 4'hA);
        check("R7 no key when flag clear", key_valid, 0);
        fe_pulse("R5 R6 packed capture", pack(3, -2));
        fe_pulse("R6 cleared after capture", 0);

        // R4: accumulate extremes within one field.
        send_msg(7, 8, 2, 4'h4, 0);
        send_msg(7, 8, 1, 4'h4, 0);
        send_msg(7, 8, 6, 4'h2, 0);
        check("R7 buttons latest", buttons, 6);
        fe_pulse("R4 accumulate", pack(21, -24));

        // R6: X delta completes in the same cycle as field_end.
        send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        @(negedge clk); ser_bit = 1'b1; ser_valid = 1'b1; field_end = 1'b1;
        @(negedge clk); ser_bit = 1'b0; ser_valid = 1'b0; field_end = 1'b0;
        check("R6 same-cycle snapshot", mouse_word, 0);
        check("R6 same-cycle post", mouse_post, 1);
        send_field(1, 4); send_field(0, 3); send_field(0, 4);
        fe_pulse("R6 same-cycle delta kept", pack(5, 1));

        // R8 R9: keyed messages fill the queue in order.
        send_msg(0, 0, 0, 4'h1, 8'h47);
        check("R8 key pushed", key_valid, 1);
        check("R8 key code", key_code, 8'h47);
        send_msg(1, 0, 0, 4'h9, 8'h80);
        check("R9 head keeps oldest", key_code, 8'h47);
        // R10: a third key overflows.
        send_msg(0, 1, 0, 4'h1, 8'h11);
        check("R10 overrun set", key_overrun, 1);
        check("R10 head unchanged", key_code, 8'h47);
        pop_key;
        check("R9 second key", key_code, 8'h80);
        pop_key;
        check("R9 empty after pops", key_valid, 0);
        check("R10 overrun sticky", key_overrun, 1);
        send_msg(0, 0, 0, 4'h1, 8'h33);
        check("R8 key after drain", key_code, 8'h33);
        fe_pulse("R4 sum across keyed msgs", pack(1, 1));

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule